// File: doc/BRIEF.md
# Byte-Lane Pipelined Memory Datapath

A synchronous single-port memory holding 64-bit words split into eight 8-bit lanes. Every input is captured on the rising clock edge: address, write data, chip select, a global write strobe, a byte-write master strobe and eight per-lane strobes. All strobes are active low. A captured write lands in the array on the following edge without any further strobe. A captured read loads an output register on the following edge, so read data appears one clock after the address was taken.

The data output is modelled as a value plus a drive flag, `drive_en_o`, which stands in for a high-impedance bus. The drive flag is gated with no clock by the output enable and the sleep input. It also drops while a write sits in the input registers, so the bus is free for incoming data. Address generation and burst sequencing happen outside this block.

Top module: `bytelane_pipe_mem`

## Requirements
- R1: Lane strobe bit n of `lane_n_i` (n = 0..7) governs data bits 8n+7 down to 8n. Bit 0 is the lowest byte.
- R2: A captured cycle with `sel_n_i`=0 and `gwr_n_i`=0 writes all eight lanes of `wdata_i`, whatever `bwm_n_i` and `lane_n_i` hold.
- R3: With `gwr_n_i`=1 and `bwm_n_i`=0, exactly the lanes whose `lane_n_i` bit is 0 are written. All other lanes of the word keep their contents.
- R4: With `gwr_n_i`=1, and either `bwm_n_i`=1 or `lane_n_i`=8'hFF, the cycle is a read and the array is unchanged.
- R5: For a read captured at edge E, `rdata_o` carries the stored word and `drive_en_o`=1 after edge E+1, provided the output enable is low and no write was captured at E+1.
- R6: `oe_n_i`=1 clears `drive_en_o` at once, without a clock edge, and clearing it to 0 restores the drive at once.
- R7: While a write captured at the edge after a read is held in the input registers, the output is not driven.
- R8: A cycle captured with `sel_n_i`=1 writes nothing and produces no driven output.
- R9: `sleep_i`=1 clears `drive_en_o` at once, and any cycle captured while it is high acts as deselected. Stored data survives sleep.
- R10: During reset and after it, until the first read, `drive_en_o`=0 and `rdata_o`=0.
- R11: Whenever `drive_en_o`=0, `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| sel_n_i | input | 1 | Chip select, active low |
| gwr_n_i | input | 1 | Global write, active low, writes every lane |
| bwm_n_i | input | 1 | Byte-write master, active low, qualifies the lane strobes |
| lane_n_i | input | 8 | Per-lane write strobes, active low |
| addr_i | input | AW ($clog2(DEPTH)) | Word address |
| wdata_i | input | 64 | Write data |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| sleep_i | input | 1 | Sleep, active high, forces the output off |
| rdata_o | output | 64 | Read data, zero when not driven |
| drive_en_o | output | 1 | 1 when the data output would be driven |

## Verification
The hardest case to reach is a write captured on the very edge at which the previous read's data lands in the output register. In that case the output flag must stay low even though valid read data is waiting. A directed sequence issues a read, then a write on the next cycle with the output enable held low, and samples the flag between the two edges. The other difficult cases are the two gates that act with no clock: output enable and sleep. The bench changes them in the middle of a cycle while read data is held, and checks the flag before the next edge. Mixed random traffic uses all three strobe forms across a fully initialised array. That traffic catches lane masking errors against a reference model that is masked byte by byte.

// File: rtl/bytelane_pipe_mem.sv
module bytelane_pipe_mem #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DW = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_i,
  input  logic             gwr_n_i,
  input  logic             bwm_n_i,
  input  logic [LANES-1:0] lane_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             oe_n_i,
  input  logic             sleep_i,
  output logic [DW-1:0]    rdata_o,
  output logic             drive_en_o
);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    dout_q;
  logic [LANES-1:0] wmask_q;
  logic             rd_q;
  logic             vld_q;

  logic             sel;
  logic [LANES-1:0] lane_we;
  logic             rd_req;
  logic             wr_req;

  assign sel     = !sel_n_i && !sleep_i;
  assign lane_we = !gwr_n_i ? '1 : (!bwm_n_i ? ~lane_n_i : '0);
  assign rd_req  = sel && (lane_we == '0);
  assign wr_req  = sel && (lane_we != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wmask_q <= '0;
      rd_q    <= 1'b0;
      vld_q   <= 1'b0;
      dout_q  <= '0;
    end else begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wmask_q <= sel ? lane_we : '0;
      rd_q    <= rd_req;
      vld_q   <= rd_q;
      if (rd_q) dout_q <= mem[addr_q];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (wmask_q[l]) mem[addr_q][l*LANE_W +: LANE_W] <= wdata_q[l*LANE_W +: LANE_W];
  end

  assign drive_en_o = vld_q && !oe_n_i && !sleep_i && (wmask_q == '0);
  assign rdata_o    = drive_en_o ? dout_q : '0;

  logic [DW-1:0] bitmask_q;
  always_comb
    for (int l = 0; l < LANES; l++) bitmask_q[l*LANE_W +: LANE_W] = {LANE_W{wmask_q[l]}};

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_i && !sleep_i && !gwr_n_i) |=> (wmask_q == '1)); // R2

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_i || sleep_i) |=> (wmask_q == '0)); // R8

  AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask_q != '0) |=> (((mem[$past(addr_q)] ^ $past(mem[addr_q])) & ~$past(bitmask_q)) == '0)); // R3

  AST_MASKED_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask_q != '0) |=> (((mem[$past(addr_q)] ^ $past(wdata_q)) & $past(bitmask_q)) == '0)); // R1

  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o |-> ($past(rd_req, 2) && !$past(wr_req))); // R5

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en_o |-> (rdata_o == '0)); // R11

endmodule

// File: tb/bytelane_pipe_mem_tb_top.sv
module bytelane_pipe_mem_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, gwr_n = 1'b1, bwm_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [7:0]  lane_n = 8'hFF;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        drv;

  logic [63:0] refm [DEPTH];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bytelane_pipe_mem #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .gwr_n_i(gwr_n), .bwm_n_i(bwm_n),
    .lane_n_i(lane_n), .addr_i(addr), .wdata_i(wdata), .oe_n_i(oe_n), .sleep_i(sleep),
    .rdata_o(rdata), .drive_en_o(drv));

  function automatic logic [63:0] exp_mask(logic g_n, logic b_n, logic [7:0] l_n);
    logic [63:0] m = '0;
    for (int l = 0; l < 8; l++)
      if (!g_n || (!b_n && !l_n[l])) m[l*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    sel_n = 1'b1; gwr_n = 1'b1; bwm_n = 1'b1; lane_n = 8'hFF;
  endtask

  task automatic wr(logic s_n, logic g_n, logic b_n, logic [7:0] l_n, logic [7:0] a, logic [63:0] d);
    logic [63:0] m;
    sel_n = s_n; gwr_n = g_n; bwm_n = b_n; lane_n = l_n; addr = a; wdata = d;
    step();
    m = exp_mask(g_n, b_n, l_n);
    if (!s_n && !sleep) refm[a] = (refm[a] & ~m) | (d & m);
    idle();
  endtask

  task automatic rd_chk(logic [7:0] a, string req);
    sel_n = 1'b0; gwr_n = 1'b1; bwm_n = 1'b1; lane_n = 8'hFF; addr = a;
    step();
    idle();
    step();
    chk({req, " drive"}, {63'd0, drv}, 64'd1);
    chk({req, " data"}, rdata, refm[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  a;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R10 reset drive", {63'd0, drv}, 64'd0);
    chk("R10 reset data", rdata, 64'd0);
    rst_n = 1'b1;
    step();
    chk("R10 after reset drive", {63'd0, drv}, 64'd0);

    for (int i = 0; i < DEPTH; i++) wr(1'b0, 1'b0, 1'b1, 8'h00, 8'(i), {$urandom, $urandom});
    rd_chk(8'd5, "R2 global init");

    // R2: global write ignores master and lane strobes
    wr(1'b0, 1'b0, 1'b1, 8'hFF, 8'd10, 64'h0123_4567_89AB_CDEF);
    rd_chk(8'd10, "R2 global override");

    // R1: one lane at a time
    for (int k = 0; k < 8; k++) begin
      wr(1'b0, 1'b1, 1'b0, ~(8'd1 << k), 8'd20, {8{8'(8'hA0 + k)}});
      rd_chk(8'd20, "R1 single lane");
    end

    // R3: mixed lane pattern
    wr(1'b0, 1'b1, 1'b0, 8'b0101_1010, 8'd21, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(8'd21, "R3 mixed lanes");

    // R4: read forms leave the array unchanged
    d = refm[22];
    wr(1'b0, 1'b1, 1'b1, 8'h00, 8'd22, ~d);
    rd_chk(8'd22, "R4 master high");
    wr(1'b0, 1'b1, 1'b0, 8'hFF, 8'd22, ~d);
    rd_chk(8'd22, "R4 lanes all high");

    // R8: deselected write and read
    wr(1'b1, 1'b0, 1'b1, 8'h00, 8'd23, ~refm[23]);
    rd_chk(8'd23, "R8 deselected write");
    sel_n = 1'b1; addr = 8'd23;
    step(); step();
    chk("R8 deselected read drive", {63'd0, drv}, 64'd0);

    // R5 timing: nothing before E+1, data after
    sel_n = 1'b0; addr = 8'd10;
    step();
    idle();
    chk("R5 not yet driven", {63'd0, drv}, 64'd0);
    step();
    chk("R5 driven one clock later", rdata, refm[10]);

    // R6: output enable acts without a clock
    oe_n = 1'b1;
    #1 chk("R6 oe high drive", {63'd0, drv}, 64'd0);
    chk("R11 zero when off", rdata, 64'd0);
    oe_n = 1'b0;
    #1 chk("R6 oe low restores", rdata, refm[10]);

    // R7: write right after read turns the output off
    @(negedge clk);
    sel_n = 1'b0; addr = 8'd30;
    step();
    sel_n = 1'b0; gwr_n = 1'b0; addr = 8'd31; wdata = 64'hDEAD_BEEF_0BAD_F00D;
    step();
    chk("R7 write after read drive", {63'd0, drv}, 64'd0);
    chk("R7 write after read data", rdata, 64'd0);
    refm[31] = 64'hDEAD_BEEF_0BAD_F00D;
    idle();
    step();
    rd_chk(8'd31, "R7 write landed");

    // R9: sleep gates output and blocks writes, data retained
    sel_n = 1'b0; addr = 8'd40;
    step();
    idle();
    step();
    chk("R9 before sleep", rdata, refm[40]);
    sleep = 1'b1;
    #1 chk("R9 sleep drive", {63'd0, drv}, 64'd0);
    @(negedge clk);
    wr(1'b0, 1'b0, 1'b1, 8'h00, 8'd40, ~refm[40]);
    step(); step();
    sleep = 1'b0;
    step(); step();
    rd_chk(8'd40, "R9 retained");

    // random mix
    for (int i = 0; i < 600; i++) begin
      a = 8'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: wr(1'b0, 1'b0, $urandom_range(0, 1) == 1, 8'($urandom), a, {$urandom, $urandom});
        1: wr(1'b0, 1'b1, 1'b0, 8'($urandom), a, {$urandom, $urandom});
        2: wr($urandom_range(0, 1) == 1, 1'b1, $urandom_range(0, 1) == 1, 8'($urandom), a, {$urandom, $urandom});
        default: rd_chk(a, "R3 random read");
      endcase
    end
    for (int i = 0; i < 16; i++) rd_chk(8'(i), "R3 final sweep");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule